// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a 32-lane execution group and the memory system. It takes a single request that carries one 4-byte word address per lane and a mask saying which lanes take part. From it the block produces the fewest naturally aligned memory transactions that cover every active lane. Each transaction is 32, 64 or 128 bytes long. Lanes whose words fall in the same aligned 128-byte segment share one transaction. That transaction shrinks to a 64-byte or 32-byte access when all of its lanes sit inside one aligned half or quarter of the segment.

Both edges are valid/ready streams. A request is accepted only while the block holds no unserved lanes, so one request is in flight at a time. Transactions leave at a rate of one per cycle while the consumer is ready. When the consumer holds ready low, the current transaction stays on the outputs unchanged. A request is fully served once the transaction flagged as last has been taken. A request with no active lanes is accepted and produces no transaction.

Top module: `coalescer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge that accepts a request with at least one active lane until the edge where its last transaction is taken, and it is 1 again in the cycle after that edge. `in_ready` and `out_valid` are never both 1.
- R3: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, with `out_base`, `out_size` and `out_lanes` unchanged.
- R4: Each transaction serves every still-unserved active lane whose address bits [ADDR_W-1:7] match those of its leading lane. The first transaction is valid in the cycle right after the accepting edge.
- R5: `out_size` is 0 (32 bytes), with `out_base` set to the leading address with bits [4:0] cleared, when all served lanes agree on address bits [6:5].
- R6: `out_size` is 1 (64 bytes), with `out_base` set to the leading address with bits [5:0] cleared, when the served lanes agree on bit 6 but not on bit 5.
- R7: `out_size` is 2 (128 bytes), with `out_base` set to the leading address with bits [6:0] cleared, when the served lanes differ in bit 6.
- R8: The addresses of inactive lanes have no effect on any output. A request with an all-zero mask is accepted, emits no transaction, and leaves `in_ready` at 1.
- R9: Transactions come out in increasing order of their leading lane, which is the lowest-numbered lane still unserved.
- R10: `out_last` is 1 only on the final transaction of a request, and `out_valid` is 0 in the cycle after that transaction is taken.
- R11: The `out_lanes` masks of one request do not overlap, and their union equals the request's `in_mask`.
- R12: 32 active lanes that read the 32 words of one aligned 128-byte segment, in any lane order, give exactly one transaction. A lane-to-lane stride of 128 bytes gives 32 one-lane transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | LANES*ADDR_W | Byte address per lane; lane i occupies bits [i*ADDR_W +: ADDR_W] |
| in_mask | input | LANES | Active lanes of the request |
| out_valid | output | 1 | Transaction present |
| out_ready | input | 1 | Consumer takes the transaction |
| out_base | output | ADDR_W | Aligned base address of the transaction |
| out_size | output | 2 | 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes |
| out_lanes | output | LANES | Lanes served by this transaction |
| out_last | output | 1 | Final transaction of the current request |

## Verification
The first transaction shows up in the cycle right after the accepting edge. Each later one follows one cycle after the previous one is taken. `in_ready` returns in the cycle after the edge that takes the last transaction. The bench drives and samples on falling edges, so each expected result is read half a cycle after the rising edge that produces it. The transaction list is built ahead of time from the grouping and sizing rules, and the observed stream is compared to it entry by entry, one falling edge per accepted transaction. Stalls are held for a fixed number of falling edges, with the outputs compared against the first stalled sample at each one. Requests that produce nothing are checked at the two falling edges that follow acceptance.

// File: rtl/coal_pkg.sv
package coal_pkg;
  // Encoded transaction length
  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txn_size_e;

  // log2 of the largest segment in bytes
  localparam int unsigned SEG_LG = 7;
endpackage

// File: rtl/coal_leader.sv
// Picks the lowest-numbered pending lane.
module coal_leader #(
  parameter int unsigned LANES = 32,
  localparam int unsigned LIDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  pending,
  output logic [LIDX_W-1:0] lead_idx,
  output logic              any_pending
);
  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) lead_idx = LIDX_W'(i);
    end
  end

  assign any_pending = |pending;
endmodule

// File: rtl/coal_match.sv
// Per-lane segment compare against the leading address.
module coal_match
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [LANES-1:0][ADDR_W-1:0] addrs,
  input  logic [LANES-1:0]             pending,
  input  logic [ADDR_W-1:0]            lead_addr,
  output logic [LANES-1:0]             hit,
  output logic                         split_half,
  output logic                         split_quarter
);
  localparam int unsigned HALF_BIT = SEG_LG - 1;
  localparam int unsigned QTR_BIT  = SEG_LG - 2;

  logic [LANES-1:0] half_diff;
  logic [LANES-1:0] qtr_diff;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic same_seg;
    assign same_seg     = (addrs[g][ADDR_W-1:SEG_LG] == lead_addr[ADDR_W-1:SEG_LG]);
    assign hit[g]       = pending[g] & same_seg;
    assign half_diff[g] = hit[g] & (addrs[g][HALF_BIT] != lead_addr[HALF_BIT]);
    assign qtr_diff[g]  = hit[g] & (addrs[g][QTR_BIT]  != lead_addr[QTR_BIT]);
  end

  assign split_half    = |half_diff;
  assign split_quarter = |qtr_diff;
endmodule

// File: rtl/coal_size.sv
// Chooses the transaction length and aligns the base.
module coal_size
  import coal_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic              split_half,
  input  logic              split_quarter,
  output txn_size_e         size,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] ALIGN_128 = ~((ADDR_W'(1) << SEG_LG) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ALIGN_64  = ~((ADDR_W'(1) << (SEG_LG - 1)) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ALIGN_32  = ~((ADDR_W'(1) << (SEG_LG - 2)) - ADDR_W'(1));

  always_comb begin
    if (split_half) begin
      size = SZ_128;
      base = lead_addr & ALIGN_128;
    end else if (split_quarter) begin
      size = SZ_64;
      base = lead_addr & ALIGN_64;
    end else begin
      size = SZ_32;
      base = lead_addr & ALIGN_32;
    end
  end
endmodule

// File: rtl/coalescer.sv
module coalescer
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]        in_mask,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_base,
  output logic [1:0]              out_size,
  output logic [LANES-1:0]        out_lanes,
  output logic                    out_last
);
  localparam int unsigned LIDX_W = $clog2(LANES);

  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LIDX_W-1:0]            lead_idx;
  logic                         any_pending;
  logic [ADDR_W-1:0]            lead_addr;
  logic [LANES-1:0]             hit;
  logic                         split_half;
  logic                         split_quarter;
  txn_size_e                    size;
  logic [LANES-1:0]             remain;
  logic                         accept;
  logic                         fire;

  coal_leader #(.LANES(LANES)) u_leader (
    .pending     (pend_q),
    .lead_idx    (lead_idx),
    .any_pending (any_pending)
  );

  assign lead_addr = addr_q[lead_idx];

  coal_match #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
    .addrs         (addr_q),
    .pending       (pend_q),
    .lead_addr     (lead_addr),
    .hit           (hit),
    .split_half    (split_half),
    .split_quarter (split_quarter)
  );

  coal_size #(.ADDR_W(ADDR_W)) u_size (
    .lead_addr     (lead_addr),
    .split_half    (split_half),
    .split_quarter (split_quarter),
    .size          (size),
    .base          (out_base)
  );

  assign in_ready  = ~any_pending;
  assign out_valid = any_pending;
  assign out_lanes = hit;
  assign out_size  = size;
  assign remain    = pend_q & ~hit;
  assign out_last  = (remain == '0);
  assign accept    = in_valid & in_ready;
  assign fire      = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (accept) begin
      pend_q <= in_mask;
      addr_q <= in_addr;
    end else if (fire) begin
      pend_q <= remain;
    end
  end
endmodule

// File: rtl/coalescer_chk.sv
module coalescer_chk #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  in_mask,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_base,
  input logic [1:0]        out_size,
  input logic [LANES-1:0]  out_lanes,
  input logic              out_last
);
  localparam int unsigned LIDX_W = $clog2(LANES);

  logic [LANES-1:0]  served_q;
  logic [LANES-1:0]  req_q;
  logic [LIDX_W-1:0] prev_low_q;
  logic              have_prev_q;
  logic [LIDX_W-1:0] cur_low;
  logic              fire;
  logic              accept;

  assign fire   = out_valid & out_ready;
  assign accept = in_valid & in_ready;

  always_comb begin
    cur_low = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (out_lanes[i]) cur_low = LIDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served_q    <= '0;
      req_q       <= '0;
      prev_low_q  <= '0;
      have_prev_q <= 1'b0;
    end else if (accept) begin
      served_q    <= '0;
      req_q       <= in_mask;
      have_prev_q <= 1'b0;
    end else if (fire) begin
      served_q    <= served_q | out_lanes;
      prev_low_q  <= cur_low;
      have_prev_q <= ~out_last;
    end
  end

  // R2
  excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R3
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_base)
                                   && $stable(out_size) && $stable(out_lanes)));

  // R4
  lanes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lanes != '0));

  // R5 R6 R7
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_size == 2'd0 && out_base[4:0] == '0) ||
                   (out_size == 2'd1 && out_base[5:0] == '0) ||
                   (out_size == 2'd2 && out_base[6:0] == '0)));

  // R8
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_mask == '0) |=> (in_ready && !out_valid));

  // R9
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev_q) |-> (cur_low > prev_low_q));

  // R10
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> !out_valid);

  // R11
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((served_q & out_lanes) == '0));

  // R11
  union_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |-> ((served_q | out_lanes) == req_q));
endmodule

bind coalescer coalescer_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_coalescer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mask   (in_mask),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_base  (out_base),
  .out_size  (out_size),
  .out_lanes (out_lanes),
  .out_last  (out_last)
);

// File: tb/test_coalescer.sv
module test_coalescer;
  localparam int unsigned LANES  = 32;
  localparam int unsigned ADDR_W = 32;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [LANES*ADDR_W-1:0] in_addr = '0;
  logic [LANES-1:0]        in_mask = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b1;
  logic [ADDR_W-1:0]       out_base;
  logic [1:0]              out_size;
  logic [LANES-1:0]        out_lanes;
  logic                    out_last;

  always #10 clk = ~clk;

  coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) i_coalescer (
    .clk, .rst_n, .in_valid, .in_ready, .in_addr, .in_mask,
    .out_valid, .out_ready, .out_base, .out_size, .out_lanes, .out_last
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [ADDR_W-1:0] a [LANES];
  logic [LANES-1:0]  m;
  logic [ADDR_W-1:0] exp_base  [LANES];
  logic [1:0]        exp_size  [LANES];
  logic [LANES-1:0]  exp_lanes [LANES];
  int                exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Expected transaction list from the grouping and sizing rules
  task automatic build_expected();
    logic [LANES-1:0] pend;
    pend  = m;
    exp_n = 0;
    while (pend != '0) begin
      int lead;
      logic [LANES-1:0] grp;
      bit dh, dq;
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      grp = '0; dh = 0; dq = 0;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i] && (a[i] >> 7) == (a[lead] >> 7)) begin
          grp[i] = 1'b1;
          if (a[i][6] != a[lead][6]) dh = 1;
          if (a[i][5] != a[lead][5]) dq = 1;
        end
      end
      if (dh) begin
        exp_size[exp_n] = 2'd2; exp_base[exp_n] = a[lead] & ~32'h7f;
      end else if (dq) begin
        exp_size[exp_n] = 2'd1; exp_base[exp_n] = a[lead] & ~32'h3f;
      end else begin
        exp_size[exp_n] = 2'd0; exp_base[exp_n] = a[lead] & ~32'h1f;
      end
      exp_lanes[exp_n] = grp;
      exp_n++;
      pend &= ~grp;
    end
  endtask

  task automatic run_req(input string req, input int stall);
    logic [LANES-1:0]  uni;
    logic [ADDR_W-1:0] hb;
    logic [1:0]        hs;
    logic [LANES-1:0]  hl;
    int got;
    build_expected();
    @(negedge clk);
    for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = a[i];
    in_mask   = m;
    in_valid  = 1'b1;
    out_ready = (stall == 0);
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_n == 0) begin
      // R8: empty request, nothing emitted
      check(in_ready && !out_valid, "R8", "empty req state", {in_ready, out_valid}, 2'b10);
      @(negedge clk);
      check(in_ready && !out_valid, "R8", "empty req state later", {in_ready, out_valid}, 2'b10);
      return;
    end
    // R2: busy after accept
    check(!in_ready, "R2", "in_ready after accept", in_ready, 0);
    if (stall > 0) begin
      hb = out_base; hs = out_size; hl = out_lanes;
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        // R3: held under back-pressure
        check(out_valid && out_base == hb && out_size == hs && out_lanes == hl,
              "R3", "stalled output", {out_valid, out_base, out_lanes}, {1'b1, hb, hl});
        check(!in_ready, "R2", "in_ready during stall", in_ready, 0);
      end
      out_ready = 1'b1;
    end
    got = 0;
    uni = '0;
    while (got < exp_n && got < 40) begin
      check(out_valid, req, "out_valid", out_valid, 1);
      check(out_base == exp_base[got], req, "out_base", out_base, exp_base[got]);
      check(out_size == exp_size[got], req, "out_size", out_size, exp_size[got]);
      check(out_lanes == exp_lanes[got], req, "out_lanes (R4 R9)", out_lanes, exp_lanes[got]);
      check(out_last == (got == exp_n - 1), "R10", "out_last", out_last, (got == exp_n - 1));
      uni |= out_lanes;
      got++;
      @(negedge clk);
    end
    // R10 R2: done and ready again
    check(!out_valid && in_ready, "R10", "idle after last", {out_valid, in_ready}, 2'b01);
    // R11: union of served masks
    check(uni == m, "R11", "lane union", uni, m);
  endtask

  task automatic t_reset();
    check(in_ready && !out_valid, "R1", "reset state", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic t_contig();
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 32'(4 * i);
    m = '1;
    run_req("R12 R7", 0);
    check(exp_n == 1, "R12", "contig txn count", exp_n, 1);
  endtask

  task automatic t_permuted();
    for (int i = 0; i < LANES; i++) a[i] = 32'h6000 + 32'(4 * (LANES - 1 - i));
    m = '1;
    run_req("R12", 0);
  endtask

  task automatic t_quarter();
    for (int i = 0; i < LANES; i++) a[i] = (i < 8) ? 32'h2040 + 32'(4 * i) : 32'hFFFF_0000 + 32'(i * 512);
    m = 32'h0000_00FF;
    run_req("R5 R8", 0);
  endtask

  task automatic t_half();
    for (int i = 0; i < LANES; i++) a[i] = (i < 16) ? 32'h3040 + 32'(4 * i) : 32'h7777_0000;
    m = 32'h0000_FFFF;
    run_req("R6", 0);
  endtask

  task automatic t_split_halves();
    for (int i = 0; i < LANES; i++) a[i] = 32'hABC0_0000;
    a[3]  = 32'h5000;
    a[20] = 32'h507C;
    m = (32'h1 << 3) | (32'h1 << 20);
    run_req("R7", 0);
  endtask

  task automatic t_order();
    a[0] = 32'hA000;
    for (int i = 1; i < LANES; i++) a[i] = 32'h4000 + 32'(4 * i);
    m = '1;
    run_req("R9", 0);
  endtask

  task automatic t_stride_stall();
    for (int i = 0; i < LANES; i++) a[i] = 32'h1_0000 + 32'(128 * i);
    m = '1;
    run_req("R12 R9", 3);
    check(exp_n == LANES, "R12", "stride txn count", exp_n, LANES);
  endtask

  task automatic t_empty();
    for (int i = 0; i < LANES; i++) a[i] = 32'(i * 4096);
    m = '0;
    run_req("R8", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_contig();
    t_permuted();
    t_quarter();
    t_half();
    t_split_halves();
    t_order();
    t_empty();
    t_stride_stall();
    t_contig();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule